// File: doc/BRIEF.md
# Dual-Tone and Single-Tone Digital Synthesizer

This block turns a four-bit key code into a stream of signed audio samples for a telephone-style tone dialer. It runs from a 3.579545 MHz system clock and emits one sample every 448 clocks, which is close to 8 kHz. Two 24-bit phase accumulators step at that rate. One carries the low-group frequency and the other the high-group frequency. Both feed identical half-wave parabolic shapers. The high-group tone is given a slightly larger weight than the low-group tone, and the two are summed.

The summed value is scaled by an attenuation gain of 0 to 15 dB in 1 dB steps and rounded to a 12-bit signed sample. A mode input picks one of three outputs: both tones together, one tone chosen from the key code, or silence. A squelch input forces the output to zero while the accumulators keep running. Any change of key code or mode restarts both accumulators at phase zero, so that each new tone begins cleanly.

Top module: `dual_tone_synth`

## Requirements
- R1: `tone_strobe` pulses for exactly one clock every 448 clocks (CLK_DIV). `tone_out` changes only in the cycle where `tone_strobe` is high, so attenuation or squelch changes made between strobes do not appear until the next strobe.
- R2: With mode 2'b01, key codes select these pairs of low and high frequencies in Hz:
  - 0001/0010/0011: 697 with 1209/1336/1477.
  - 0100/0101/0110: 770 with 1209/1336/1477.
  - 0111/1000/1001: 852 with 1209/1336/1477.
  - 1010: 941+1336. 1011: 941+1209. 1100: 941+1477.
  - 1101/1110/1111: 697/770/852 with 1633.
  - 0000: 941+1633.
- R3: With mode 2'b10, only one tone is produced. Codes with bit 3 clear give the low tone of that code's pair. Codes with bit 3 set give the high tone.
- R4: Each accumulator is 24 bits wide and wraps modulo 2^24. On every sample it advances by round(f * 2^24 * 448 / 3579545), which keeps every tone within 1% of its nominal frequency.
- R5: For a phase p, let x = p[22:12] and m = floor(x*(2048-x)/1024). The tone value is +m when p[23] is 0 and -m when p[23] is 1. The high tone is weighted by 16/16 and the low tone by floor(14*m/16). This gives the high group about 1 dB of emphasis.
- R6: Attenuation code n selects the gain g = min(32767, round(32768*10^(-n/20))). The output is (s*g + 16384) >>> 15 as a 12-bit two's-complement value, where s is the summed tone value.
- R7: When squelch is 1, each sample is 0. Squelch and attenuation changes do not disturb the accumulators, and the tone resumes at its running phase when squelch returns to 0.
- R8: Mode 2'b00 and mode 2'b11 give a silent output of 0.
- R9: Any change of key code or mode clears both accumulators on the next clock edge. If that edge is also a sample edge, the emitted sample uses the phases from before the clear together with the new code and mode.
- R10: During reset, `tone_out` is 0 and `tone_strobe` is 0. The reset input is synchronized over two clocks, and the first strobe comes 448 clocks after the synchronized release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 3.579545 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_code | input | 4 | Key code selecting the tone pair or single tone |
| tone_mode | input | 2 | 00 silent, 01 dual tone, 10 single tone, 11 silent |
| atten | input | 4 | Attenuation in dB, 0 to 15 |
| squelch | input | 1 | Forces the output to zero when 1 |
| tone_out | output | 12 | Signed output sample |
| tone_strobe | output | 1 | One-clock pulse marking a new sample |

## Verification
The delicate overlap is a key-code or mode change that lands on the same clock edge as a sample strobe. On that edge, the accumulator restart and the sample capture both happen at once. The bench follows the divider count in its own reference model. It changes the code and the mode exactly on the cycle before a strobe edge, and also at arbitrary points between strobes. Every output cycle is then compared against the model, which emits the pre-clear phases with the new weights and continues from zero phase afterwards.

// File: rtl/dts_pkg.sv
package dts_pkg;

  localparam int REF_CLK_HZ = 3579545;

  // Output weighting of the two groups (high group emphasised).
  localparam int LO_WEIGHT    = 14;
  localparam int HI_WEIGHT    = 16;
  localparam int WEIGHT_SHIFT = 4;

  // Gain fraction bits of the attenuation multiplier.
  localparam int GAIN_FRAC = 15;
  localparam int GAIN_W    = 16;

  localparam int LOW_HZ  [4] = '{697, 770, 852, 941};
  localparam int HIGH_HZ [4] = '{1209, 1336, 1477, 1633};

  typedef enum logic [1:0] {
    MODE_MUTE   = 2'b00,
    MODE_PAIR   = 2'b01,
    MODE_SINGLE = 2'b10,
    MODE_SPARE  = 2'b11
  } tone_mode_e;

  // Phase increment per sample for a tone, rounded to nearest.
  function automatic longint tuning_word(input int freq_hz, input int acc_w, input int div);
    longint num;
    num = (longint'(freq_hz) <<< acc_w) * longint'(div) + longint'(REF_CLK_HZ / 2);
    return num / longint'(REF_CLK_HZ);
  endfunction

  // 10^(-n/20) scaled by 2^15, unity clipped to the largest code.
  function automatic logic [GAIN_W-1:0] gain_q15(input logic [3:0] n);
    logic [GAIN_W-1:0] g;
    case (n)
      4'd0:  g = 16'd32767;
      4'd1:  g = 16'd29205;
      4'd2:  g = 16'd26029;
      4'd3:  g = 16'd23198;
      4'd4:  g = 16'd20675;
      4'd5:  g = 16'd18427;
      4'd6:  g = 16'd16423;
      4'd7:  g = 16'd14637;
      4'd8:  g = 16'd13045;
      4'd9:  g = 16'd11627;
      4'd10: g = 16'd10362;
      4'd11: g = 16'd9235;
      4'd12: g = 16'd8231;
      4'd13: g = 16'd7336;
      4'd14: g = 16'd6538;
      default: g = 16'd5827;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/dts_tick_gen.sv
module dts_tick_gen #(
  parameter int DIV = 448
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dts_code_map.sv
module dts_code_map (
  input  logic [3:0] code,
  output logic [1:0] lo_sel,
  output logic [1:0] hi_sel
);
  // lo_sel: 0=697 1=770 2=852 3=941 ; hi_sel: 0=1209 1=1336 2=1477 3=1633
  always_comb begin
    case (code)
      4'd1, 4'd2, 4'd3, 4'd13: lo_sel = 2'd0;
      4'd4, 4'd5, 4'd6, 4'd14: lo_sel = 2'd1;
      4'd7, 4'd8, 4'd9, 4'd15: lo_sel = 2'd2;
      default:                 lo_sel = 2'd3;
    endcase
    case (code)
      4'd1, 4'd4, 4'd7, 4'd11: hi_sel = 2'd0;
      4'd2, 4'd5, 4'd8, 4'd10: hi_sel = 2'd1;
      4'd3, 4'd6, 4'd9, 4'd12: hi_sel = 2'd2;
      default:                 hi_sel = 2'd3;
    endcase
  end
endmodule

// File: rtl/dts_phase_acc.sv
module dts_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase
);
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] phase_d;

  always_comb begin
    phase_d = phase_q;
    if (clear) begin
      phase_d = '0;
    end else if (advance) begin
      phase_d = phase_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/dts_wave_shape.sv
module dts_wave_shape #(
  parameter int ACC_W   = 24,
  parameter int PH_BITS = 11
) (
  input  logic [ACC_W-1:0]   phase,
  output logic               neg,
  output logic [PH_BITS-1:0] mag
);
  localparam int PW = 2 * PH_BITS + 1;

  logic [PH_BITS-1:0] x;
  logic [PH_BITS:0]   span;
  logic [PW-1:0]      bump;
  logic               unused_lsb;

  assign neg  = phase[ACC_W-1];
  assign x    = phase[ACC_W-2 -: PH_BITS];
  assign span = {1'b1, {PH_BITS{1'b0}}} - {1'b0, x};
  assign bump = PW'(x) * PW'(span);
  assign mag  = PH_BITS'(bump >> (PH_BITS - 1));
  assign unused_lsb = ^phase[ACC_W-PH_BITS-2:0];
endmodule

// File: rtl/dts_mix_gain.sv
module dts_mix_gain
  import dts_pkg::*;
#(
  parameter int PH_BITS = 11,
  parameter int OUT_W   = 12
) (
  input  logic               neg_lo,
  input  logic [PH_BITS-1:0] mag_lo,
  input  logic               neg_hi,
  input  logic [PH_BITS-1:0] mag_hi,
  input  logic [1:0]         mode,
  input  logic               hi_only,
  input  logic [3:0]         atten,
  input  logic               squelch,
  output logic [OUT_W-1:0]   sample
);
  localparam int WIDE_W = PH_BITS + 5;
  localparam int ABS_W  = PH_BITS + 1;
  localparam int TERM_W = PH_BITS + 2;
  localparam int SUM_W  = TERM_W + 1;
  localparam int PROD_W = SUM_W + GAIN_W + 1;
  localparam int ROUND_BIAS = 1 << (GAIN_FRAC - 1);

  logic [WIDE_W-1:0]        lo_wide, hi_wide;
  logic [ABS_W-1:0]         lo_abs, hi_abs;
  logic signed [TERM_W-1:0] lo_term, hi_term;
  logic signed [SUM_W-1:0]  mix_sum;
  logic [GAIN_W-1:0]        gain;
  logic signed [PROD_W-1:0] prod, rnd;
  logic                     silent;
  logic                     unused_top;

  always_comb begin
    lo_wide = WIDE_W'(mag_lo) * WIDE_W'(LO_WEIGHT);
    hi_wide = WIDE_W'(mag_hi) * WIDE_W'(HI_WEIGHT);
    lo_abs  = ABS_W'(lo_wide >> WEIGHT_SHIFT);
    hi_abs  = ABS_W'(hi_wide >> WEIGHT_SHIFT);
    lo_term = neg_lo ? -$signed({1'b0, lo_abs}) : $signed({1'b0, lo_abs});
    hi_term = neg_hi ? -$signed({1'b0, hi_abs}) : $signed({1'b0, hi_abs});

    case (tone_mode_e'(mode))
      MODE_PAIR:   mix_sum = SUM_W'(lo_term) + SUM_W'(hi_term);
      MODE_SINGLE: mix_sum = hi_only ? SUM_W'(hi_term) : SUM_W'(lo_term);
      default:     mix_sum = '0;
    endcase

    silent = squelch || (tone_mode_e'(mode) == MODE_MUTE) || (tone_mode_e'(mode) == MODE_SPARE);
    gain   = gain_q15(atten);
    prod   = PROD_W'(mix_sum) * $signed({1'b0, gain});
    rnd    = (prod + PROD_W'(ROUND_BIAS)) >>> GAIN_FRAC;
    sample = silent ? '0 : rnd[OUT_W-1:0];
  end

  assign unused_top = ^rnd[PROD_W-1:OUT_W];
endmodule

// File: rtl/dual_tone_synth.sv
module dual_tone_synth
  import dts_pkg::*;
#(
  parameter int CLK_DIV = 448,
  parameter int ACC_W   = 24,
  parameter int PH_BITS = 11,
  parameter int OUT_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       tone_code,
  input  logic [1:0]       tone_mode,
  input  logic [3:0]       atten,
  input  logic             squelch,
  output logic [OUT_W-1:0] tone_out,
  output logic             tone_strobe
);
  localparam int NCH = 2;
  localparam logic [ACC_W-1:0] LO_WORD [4] = '{
    ACC_W'(tuning_word(LOW_HZ[0], ACC_W, CLK_DIV)),
    ACC_W'(tuning_word(LOW_HZ[1], ACC_W, CLK_DIV)),
    ACC_W'(tuning_word(LOW_HZ[2], ACC_W, CLK_DIV)),
    ACC_W'(tuning_word(LOW_HZ[3], ACC_W, CLK_DIV))
  };
  localparam logic [ACC_W-1:0] HI_WORD [4] = '{
    ACC_W'(tuning_word(HIGH_HZ[0], ACC_W, CLK_DIV)),
    ACC_W'(tuning_word(HIGH_HZ[1], ACC_W, CLK_DIV)),
    ACC_W'(tuning_word(HIGH_HZ[2], ACC_W, CLK_DIV)),
    ACC_W'(tuning_word(HIGH_HZ[3], ACC_W, CLK_DIV))
  };

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic tick;
  dts_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  logic [1:0] lo_sel, hi_sel;
  dts_code_map u_map (
    .code   (tone_code),
    .lo_sel (lo_sel),
    .hi_sel (hi_sel)
  );

  // Setting-change detection restarts both accumulators.
  logic [3:0] code_seen_q;
  logic [1:0] mode_seen_q;
  logic       setting_change;

  assign setting_change = (tone_code != code_seen_q) || (tone_mode != mode_seen_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_seen_q <= '0;
      mode_seen_q <= MODE_MUTE;
    end else begin
      code_seen_q <= tone_code;
      mode_seen_q <= tone_mode;
    end
  end

  logic [ACC_W-1:0]   acc_phase [NCH];
  logic [NCH-1:0]     wave_neg;
  logic [PH_BITS-1:0] wave_mag  [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [ACC_W-1:0] step;
    if (ch == 0) begin : g_low
      assign step = LO_WORD[lo_sel];
    end else begin : g_high
      assign step = HI_WORD[hi_sel];
    end

    dts_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clear   (setting_change),
      .advance (tick),
      .step    (step),
      .phase   (acc_phase[ch])
    );

    dts_wave_shape #(.ACC_W(ACC_W), .PH_BITS(PH_BITS)) u_wave (
      .phase (acc_phase[ch]),
      .neg   (wave_neg[ch]),
      .mag   (wave_mag[ch])
    );
  end

  logic [OUT_W-1:0] mix_sample;
  dts_mix_gain #(.PH_BITS(PH_BITS), .OUT_W(OUT_W)) u_mix (
    .neg_lo  (wave_neg[0]),
    .mag_lo  (wave_mag[0]),
    .neg_hi  (wave_neg[1]),
    .mag_hi  (wave_mag[1]),
    .mode    (tone_mode),
    .hi_only (tone_code[3]),
    .atten   (atten),
    .squelch (squelch),
    .sample  (mix_sample)
  );

  // Output register, loaded only on the sample tick.
  logic [OUT_W-1:0] tone_q, tone_d;
  logic             strobe_q, strobe_d;

  always_comb begin
    tone_d   = tone_q;
    if (tick) begin
      tone_d = mix_sample;
    end
    strobe_d = tick;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tone_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      tone_q   <= tone_d;
      strobe_q <= strobe_d;
    end
  end

  assign tone_out    = tone_q;
  assign tone_strobe = strobe_q;
endmodule

// File: rtl/dts_checker.sv
module dts_checker
  import dts_pkg::*;
#(
  parameter int CLK_DIV = 448,
  parameter int ACC_W   = 24,
  parameter int PH_BITS = 11,
  parameter int OUT_W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [3:0]       tone_code,
  input logic [1:0]       tone_mode,
  input logic             squelch,
  input logic [OUT_W-1:0] tone_out,
  input logic             tone_strobe,
  input logic [ACC_W-1:0] phase_lo,
  input logic [ACC_W-1:0] phase_hi
);
  localparam int PEAK = ((LO_WEIGHT + HI_WEIGHT) << (PH_BITS - 1)) >> WEIGHT_SHIFT;
  localparam int GW   = $clog2(CLK_DIV + 1) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (tone_strobe) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  assert_strobe_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_strobe && seen_q) |-> (gap_q == GW'(CLK_DIV - 1)));

  assert_hold_between_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_strobe |-> $stable(tone_out));

  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(tone_out) <= PEAK) && ($signed(tone_out) >= -PEAK));

  assert_squelch_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && squelch) |=> (tone_out == '0));

  assert_mute_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (tone_mode == 2'b00 || tone_mode == 2'b11)) |=> (tone_out == '0));

  assert_phase_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && (tone_code != $past(tone_code) || tone_mode != $past(tone_mode)))
      |=> (phase_lo == '0 && phase_hi == '0));
endmodule

bind dual_tone_synth dts_checker #(
  .CLK_DIV (CLK_DIV),
  .ACC_W   (ACC_W),
  .PH_BITS (PH_BITS),
  .OUT_W   (OUT_W)
) u_check (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tick        (tick),
  .tone_code   (tone_code),
  .tone_mode   (tone_mode),
  .squelch     (squelch),
  .tone_out    (tone_out),
  .tone_strobe (tone_strobe),
  .phase_lo    (acc_phase[0]),
  .phase_hi    (acc_phase[1])
);

// File: tb/sim_dual_tone_synth.sv
module sim_dual_tone_synth;
  localparam int DIV = 448;

  logic       clk   = 1'b0;
  logic       rst_n = 1'b1;
  logic [3:0] code  = 4'd0;
  logic [1:0] mode  = 2'b00;
  logic [3:0] att   = 4'd0;
  logic       sq    = 1'b0;
  logic [11:0] tone_out;
  logic        tone_strobe;

  always #10 clk = ~clk;

  dual_tone_synth u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .tone_code   (code),
    .tone_mode   (mode),
    .atten       (att),
    .squelch     (sq),
    .tone_out    (tone_out),
    .tone_strobe (tone_strobe)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    running = 0;
  bit    done = 0;
  string cur_req = "R10";

  // ---------------- reference model ----------------
  function automatic int lo_hz(input int c);
    case (c)
      1, 2, 3, 13: return 697;
      4, 5, 6, 14: return 770;
      7, 8, 9, 15: return 852;
      default:     return 941;
    endcase
  endfunction

  function automatic int hi_hz(input int c);
    case (c)
      1, 4, 7, 11: return 1209;
      2, 5, 8, 10: return 1336;
      3, 6, 9, 12: return 1477;
      default:     return 1633;
    endcase
  endfunction

  function automatic int word_of(input int f);
    return $rtoi(real'(f) * 16777216.0 * 448.0 / 3579545.0 + 0.5);
  endfunction

  function automatic int gain_of(input int n);
    int g;
    g = $rtoi(32768.0 * (10.0 ** (-real'(n) / 20.0)) + 0.5);
    return (g > 32767) ? 32767 : g;
  endfunction

  function automatic int shape(input int ph);
    int x, m;
    x = (ph >> 12) & 2047;
    m = (x * (2048 - x)) / 1024;
    return (ph >= 8388608) ? -m : m;
  endfunction

  function automatic int weigh_lo(input int v);
    return (v < 0) ? -(((-v) * 14) / 16) : ((v * 14) / 16);
  endfunction

  function automatic int ref_sample(input int c, input int md, input int a, input int s,
                                    input int p0, input int p1);
    int lo, hi, sum;
    if (s != 0 || md == 0 || md == 3) return 0;
    lo = weigh_lo(shape(p0));
    hi = shape(p1);
    if (md == 1) sum = lo + hi;
    else sum = (c >= 8) ? hi : lo;
    return (sum * gain_of(a) + 16384) >>> 15;
  endfunction

  int m_ph0, m_ph1, m_cnt, m_rel, m_out, m_pcode, m_pmode;
  bit m_stb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_cnt = 0; m_ph0 = 0; m_ph1 = 0; m_out = 0; m_stb = 0;
      m_pcode = 0; m_pmode = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit tk, chg;
      tk  = (m_cnt == DIV - 1);
      chg = (int'(code) != m_pcode) || (int'(mode) != m_pmode);
      if (tk) m_out = ref_sample(int'(code), int'(mode), int'(att), int'(sq), m_ph0, m_ph1);
      m_stb = tk;
      if (chg) begin
        m_ph0 = 0; m_ph1 = 0;
      end else if (tk) begin
        m_ph0 = (m_ph0 + word_of(lo_hz(int'(code)))) & 24'hFFFFFF;
        m_ph1 = (m_ph1 + word_of(hi_hz(int'(code)))) & 24'hFFFFFF;
      end
      m_pcode = int'(code);
      m_pmode = int'(mode);
      m_cnt   = tk ? 0 : m_cnt + 1;
    end
  end

  // ---------------- comparison on every clock ----------------
  always @(negedge clk) begin
    if (running && !done) begin
      n_cmp++;
      if ($signed(tone_out) != m_out || tone_strobe != m_stb) begin
        n_bad++;
        $display("FAIL %s: actual out=%0d strobe=%0b expected out=%0d strobe=%0b",
                 cur_req, $signed(tone_out), tone_strobe, m_out, m_stb);
      end
    end
  end

  task automatic drive(input int c, input int md, input int a, input int s);
    @(negedge clk);
    code = 4'(c); mode = 2'(md); att = 4'(a); sq = (s != 0);
  endtask

  task automatic samples(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic align_to_tick;
    do @(negedge clk); while (m_cnt != DIV - 1);
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R10: reset state
    n_cmp++;
    if (tone_out != 12'd0 || tone_strobe != 1'b0) begin
      n_bad++;
      $display("FAIL R10: actual out=%0d strobe=%0b expected out=0 strobe=0",
               $signed(tone_out), tone_strobe);
    end
    running = 1;
    @(negedge clk) rst_n = 1'b1;
    cur_req = "R10";
    repeat (DIV + 8) @(negedge clk);

    // R2: every key code as a pair
    cur_req = "R2";
    for (int c = 0; c < 16; c++) begin
      drive(c, 1, 0, 0);
      samples(5);
    end

    // R3: single-tone selection by bit 3
    cur_req = "R3";
    for (int c = 0; c < 16; c++) begin
      drive(c, 2, 0, 0);
      samples(3);
    end

    // R4 / R5: long run covering full phase cycles of both groups
    cur_req = "R4 R5";
    drive(13, 1, 0, 0);
    samples(40);

    // R6: attenuation sweep, changed mid-interval (also R1 hold)
    cur_req = "R6 R1";
    drive(5, 1, 0, 0);
    samples(1);
    repeat (DIV / 3) @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      drive(5, 1, a, 0);
      samples(2);
    end

    // R7: squelch mutes, phase keeps running
    cur_req = "R7";
    drive(5, 1, 3, 1);
    samples(3);
    drive(5, 1, 3, 0);
    samples(3);

    // R8: silent modes
    cur_req = "R8";
    drive(5, 0, 0, 0);
    samples(2);
    drive(5, 3, 0, 0);
    samples(2);

    // R9: code and mode changes on the sample edge and between edges
    cur_req = "R9";
    drive(6, 1, 0, 0);
    samples(4);
    align_to_tick();
    code = 4'd9;
    samples(3);
    align_to_tick();
    mode = 2'b10;
    samples(3);
    repeat (100) @(negedge clk);
    code = 4'd12;
    samples(3);
    drive(12, 1, 0, 0);
    samples(3);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule